// File: doc/BRIEF.md
# Single-Cycle Nine-Instruction RISC Core

This block is a 32-bit processor core that completes one instruction in every clock cycle. It fetches a word from an instruction port, decodes it, reads two source registers, runs the ALU and data memory access, and writes back the result. The next program counter is also chosen in the same cycle. Both memory ports are outside the core. The instruction port is read combinationally from the current program counter. The data port gives a combinational read and a write strobe, and the write is taken on the next rising clock edge.

Decoding happens in two levels. A main decoder maps the opcode to the datapath selects and a 2-bit ALU class. A second decoder turns that class, plus the funct field for register-register instructions, into a 4-bit ALU operation. Three next-PC sources are supported: sequential, taken branch-on-equal and absolute jump. Any opcode outside the supported set leaves the registers and memory untouched.

Top module: `risc9_core`

## Requirements
- R1: A synchronous active-high reset sets the program counter to 0 and clears every register. The first fetch after reset is from address 0, and every register then reads as 0.
- R2: Every instruction other than a taken branch or a jump advances the program counter by 4 on the next clock edge.
- R3: With opcode 0x00, the destination is rd (bits 15-11), the sources are rs (bits 25-21) and rt (bits 20-16), and funct is bits 5-0. The funct codes are 0x20 add, 0x22 subtract, 0x24 bitwise AND and 0x25 bitwise OR, all 32-bit with overflow ignored.
- R4: Opcode 0x00 with funct 0x2A writes 1 to rd when rs is less than rt as signed numbers, and writes 0 otherwise.
- R5: Opcode 0x23 (load) drives the data address with rs plus the sign-extended 16-bit immediate (bits 15-0) and raises the read strobe. It writes the returned data to rt.
- R6: Opcode 0x2B (store) drives the same address form, drives the rt value as write data and raises the write strobe for that one cycle.
- R7: Opcode 0x04 compares rs with rt. When they are equal, the next program counter is PC+4 plus the sign-extended immediate shifted left by 2. When they differ, it is PC+4.
- R8: Opcode 0x02 makes the next program counter equal to bits 31-28 of PC+4, then the 26-bit field in bits 25-0, then two zero bits.
- R9: Register 0 always reads as 0, and writes to it are discarded.
- R10: An opcode outside {0x00, 0x02, 0x04, 0x23, 0x2B} writes no register and no memory, and the program counter advances by 4.
- R11: The write strobe is high only for a store and the read strobe only for a load. The two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 32 | Current program counter, the fetch address |
| imem_rdata | input | 32 | Instruction word at imem_addr, same cycle |
| dmem_addr | output | 32 | Data byte address (base plus offset) |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, taken at the next rising edge |
| dmem_re | output | 1 | Load strobe |
| dmem_rdata | input | 32 | Load data at dmem_addr, same cycle |

## Verification
A wrong program counter shows up on the fetch address in the cycle right after the faulty branch, jump or increment. A register written with a wrong value, or written when it should not have been, stays hidden until a later store or load uses it. The error then appears on the data address or store data. The bench therefore mixes frequent stores into its random stream so that register damage surfaces within a few instructions. Decoder faults in the strobes are visible on the data port in the same cycle as the offending instruction.

// File: rtl/core_pkg.sv
package core_pkg;

  localparam logic [5:0] OPC_RTYPE = 6'h00;
  localparam logic [5:0] OPC_JMP   = 6'h02;
  localparam logic [5:0] OPC_BEQ   = 6'h04;
  localparam logic [5:0] OPC_LOAD  = 6'h23;
  localparam logic [5:0] OPC_STORE = 6'h2B;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [3:0] {
    ALU_AND = 4'b0000,
    ALU_OR  = 4'b0001,
    ALU_ADD = 4'b0010,
    ALU_SUB = 4'b0110,
    ALU_SLT = 4'b0111
  } alu_op_e;

  typedef enum logic [1:0] {
    AOP_ADD   = 2'b00,
    AOP_SUB   = 2'b01,
    AOP_FUNCT = 2'b10
  } alu_class_e;

  typedef struct packed {
    logic       dst_rd;
    logic       jump;
    logic       branch;
    logic       mem_rd;
    logic       wb_from_mem;
    logic       mem_wr;
    logic       src_imm;
    logic       reg_wr;
    alu_class_e aop;
  } ctrl_t;

  function automatic logic [31:0] sext16(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  function automatic logic [31:0] branch_target(input logic [31:0] pc4,
                                                input logic [15:0] off);
    return pc4 + (sext16(off) << 2);
  endfunction

  function automatic logic [31:0] jump_target(input logic [31:0] pc4,
                                              input logic [25:0] field);
    return {pc4[31:28], field, 2'b00};
  endfunction

endpackage

// File: rtl/ctrl_decode.sv
module ctrl_decode
  import core_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl,
  output alu_op_e    alu_op
);

  // level 1: opcode to datapath selects
  always_comb begin
    ctrl = '0;
    ctrl.aop = AOP_ADD;
    unique case (opcode)
      OPC_RTYPE: begin
        ctrl.dst_rd = 1'b1;
        ctrl.reg_wr = 1'b1;
        ctrl.aop    = AOP_FUNCT;
      end
      OPC_LOAD: begin
        ctrl.src_imm     = 1'b1;
        ctrl.mem_rd      = 1'b1;
        ctrl.wb_from_mem = 1'b1;
        ctrl.reg_wr      = 1'b1;
      end
      OPC_STORE: begin
        ctrl.src_imm = 1'b1;
        ctrl.mem_wr  = 1'b1;
      end
      OPC_BEQ: begin
        ctrl.branch = 1'b1;
        ctrl.aop    = AOP_SUB;
      end
      OPC_JMP: ctrl.jump = 1'b1;
      default: ;
    endcase
  end

  // level 2: class plus funct to ALU operation
  always_comb begin
    alu_op = ALU_ADD;
    case (ctrl.aop)
      AOP_SUB:   alu_op = ALU_SUB;
      AOP_FUNCT: begin
        case (funct)
          FN_SUB:  alu_op = ALU_SUB;
          FN_AND:  alu_op = ALU_AND;
          FN_OR:   alu_op = ALU_OR;
          FN_SLT:  alu_op = ALU_SLT;
          default: alu_op = ALU_ADD;
        endcase
      end
      default:   alu_op = ALU_ADD;
    endcase
  end

endmodule

// File: rtl/alu_unit.sv
module alu_unit
  import core_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y,
  output logic         zero
);

  logic [W-1:0] diff;
  logic         lt_signed;

  assign diff      = a - b;
  assign lt_signed = (a[W-1] != b[W-1]) ? a[W-1] : diff[W-1];

  always_comb begin
    case (op)
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SUB: y = diff;
      ALU_SLT: y = {{(W-1){1'b0}}, lt_signed};
      default: y = a + b;
    endcase
  end

  assign zero = (y == '0);

  // R4
  always_comb begin
    if (op == ALU_SLT) begin
      slt_bool_chk: assert (y[W-1:1] == '0 &&
                            y[0] == ($signed(a) < $signed(b)))
        else $error("slt result not a signed boolean");
    end
  end

endmodule

// File: rtl/regfile.sv
module regfile #(
  parameter int NREG = 32,
  parameter int W    = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_a,
  output logic [W-1:0]  rdata_b
);

  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    for (int i = 0; i < NREG; i++) begin
      if (rst)
        regs[i] <= '0;
      else if (we && waddr == AW'(i) && i != 0)
        regs[i] <= wdata;
    end
  end

  assign rdata_a = (raddr_a == '0) ? '0 : regs[raddr_a];
  assign rdata_b = (raddr_b == '0) ? '0 : regs[raddr_b];

  // R9
  zero_reg_chk: assert property (@(posedge clk) disable iff (rst)
    (raddr_a == '0) |-> (rdata_a == '0))
    else $error("register 0 read non-zero");

endmodule

// File: rtl/risc9_core.sv
module risc9_core
  import core_pkg::*;
#(
  parameter int          NREG     = 32,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] imem_addr,
  input  logic [31:0] imem_rdata,
  output logic [31:0] dmem_addr,
  output logic [31:0] dmem_wdata,
  output logic        dmem_we,
  output logic        dmem_re,
  input  logic [31:0] dmem_rdata
);

  localparam int AW = $clog2(NREG);

  logic [31:0] pc_q, pc_plus4, next_pc;
  logic [5:0]  f_op, f_fn;
  logic [4:0]  f_rs, f_rt, f_rd;
  logic [15:0] f_imm;
  logic [25:0] f_tgt;
  ctrl_t       ctrl;
  alu_op_e     alu_op;
  logic [31:0] rs_val, rt_val, alu_b, alu_y, wb_data;
  logic [4:0]  wb_addr;
  logic        alu_zero;
  logic        br_taken, take_seq;

  assign f_op  = imem_rdata[31:26];
  assign f_rs  = imem_rdata[25:21];
  assign f_rt  = imem_rdata[20:16];
  assign f_rd  = imem_rdata[15:11];
  assign f_fn  = imem_rdata[5:0];
  assign f_imm = imem_rdata[15:0];
  assign f_tgt = imem_rdata[25:0];

  ctrl_decode u_dec (
    .opcode (f_op),
    .funct  (f_fn),
    .ctrl   (ctrl),
    .alu_op (alu_op)
  );

  assign wb_addr = ctrl.dst_rd ? f_rd : f_rt;
  assign wb_data = ctrl.wb_from_mem ? dmem_rdata : alu_y;

  regfile #(.NREG(NREG), .W(32)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .we      (ctrl.reg_wr),
    .waddr   (AW'(wb_addr)),
    .wdata   (wb_data),
    .raddr_a (AW'(f_rs)),
    .raddr_b (AW'(f_rt)),
    .rdata_a (rs_val),
    .rdata_b (rt_val)
  );

  assign alu_b = ctrl.src_imm ? sext16(f_imm) : rt_val;

  alu_unit #(.W(32)) u_alu (
    .a    (rs_val),
    .b    (alu_b),
    .op   (alu_op),
    .y    (alu_y),
    .zero (alu_zero)
  );

  assign pc_plus4 = pc_q + 32'd4;
  assign br_taken = ctrl.branch & alu_zero;
  assign take_seq = ~br_taken & ~ctrl.jump;

  always_comb begin
    next_pc = pc_plus4;
    if (ctrl.jump)
      next_pc = jump_target(pc_plus4, f_tgt);
    else if (br_taken)
      next_pc = branch_target(pc_plus4, f_imm);
  end

  always_ff @(posedge clk) begin
    if (rst) pc_q <= RESET_PC;
    else     pc_q <= next_pc;
  end

  assign imem_addr  = pc_q;
  assign dmem_addr  = alu_y;
  assign dmem_wdata = rt_val;
  assign dmem_we    = ctrl.mem_wr;
  assign dmem_re    = ctrl.mem_rd;

  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    take_seq |=> (pc_q == $past(pc_plus4)))
    else $error("sequential step not PC+4");

  // R7
  br_equal_chk: assert property (@(posedge clk) disable iff (rst)
    br_taken |-> (ctrl.branch && rs_val == rt_val))
    else $error("branch taken with unequal operands");

  // R8
  jump_region_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl.jump |=> (pc_q[31:28] == $past(pc_plus4[31:28]) && pc_q[1:0] == 2'b00))
    else $error("jump left its region or is unaligned");

  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(dmem_we && dmem_re))
    else $error("read and write strobes together");

  // R10
  store_only_chk: assert property (@(posedge clk) disable iff (rst)
    dmem_we |-> (imem_rdata[31:26] == OPC_STORE))
    else $error("write strobe on non-store");

endmodule

// File: tb/risc9_core_tb_top.sv
`timescale 1ns/1ps
module risc9_core_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we, dmem_re;

  always #2 clk = ~clk;

  risc9_core dut_i (
    .clk(clk), .rst(rst),
    .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
    .dmem_we(dmem_we), .dmem_re(dmem_re), .dmem_rdata(dmem_rdata)
  );

  logic [31:0] dmem [64];
  assign dmem_rdata = dmem[dmem_addr[7:2]];
  always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;

  logic [31:0] mreg [32];
  logic [31:0] mdm  [64];
  logic [31:0] mpc;
  string       pc_tag;
  int          n_chk, n_fail;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(input logic [5:0] fn, input logic [4:0] rd,
                                        input logic [4:0] rs, input logic [4:0] rt);
    return {6'h00, rs, rt, rd, 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs,
                                        input logic [4:0] rt, input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  function automatic logic [31:0] ref_rop(input logic [5:0] fn, input logic [31:0] a,
                                          input logic [31:0] b);
    case (fn)
      6'h20: return a + b;
      6'h22: return a + ~b + 32'd1;
      6'h24: return a & b;
      6'h25: return a | b;
      6'h2A: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      default: return a + b;
    endcase
  endfunction

  // Called at a falling edge; leaves at the next falling edge.
  task automatic step(input logic [31:0] ins, input bit xchk = 1'b0,
                      input string xreq = "", input logic [31:0] xexp = 32'd0);
    logic [5:0]  op;
    logic [4:0]  rs, rt, rd;
    logic [31:0] a, b, se, ea, npc;
    string       sreq;
    imem_rdata = ins;
    #1;
    op = ins[31:26]; rs = ins[25:21]; rt = ins[20:16]; rd = ins[15:11];
    a  = mreg[rs]; b = mreg[rt];
    se = {{16{ins[15]}}, ins[15:0]};
    ea = a + se;
    npc = mpc + 32'd4;
    chk(pc_tag, imem_addr, mpc);
    sreq = (op inside {6'h00, 6'h02, 6'h04, 6'h23, 6'h2B}) ? "R11" : "R10";
    pc_tag = (sreq == "R10") ? "R10" : "R2";
    case (op)
      6'h00: begin
        if (rd != 0) mreg[rd] = ref_rop(ins[5:0], a, b);
        chk(sreq, {31'd0, dmem_we}, 32'd0);
        chk(sreq, {31'd0, dmem_re}, 32'd0);
      end
      6'h23: begin
        chk("R5", dmem_addr, ea);
        chk("R5", {31'd0, dmem_re}, 32'd1);
        chk("R11", {31'd0, dmem_we}, 32'd0);
        if (rt != 0) mreg[rt] = mdm[ea[7:2]];
      end
      6'h2B: begin
        chk("R6", dmem_addr, ea);
        chk("R6", dmem_wdata, b);
        chk("R6", {31'd0, dmem_we}, 32'd1);
        chk("R11", {31'd0, dmem_re}, 32'd0);
        mdm[ea[7:2]] = b;
      end
      6'h04: begin
        if (a == b) npc = npc + {se[29:0], 2'b00};
        pc_tag = "R7";
        chk(sreq, {31'd0, dmem_we}, 32'd0);
      end
      6'h02: begin
        npc = {npc[31:28], ins[25:0], 2'b00};
        pc_tag = "R8";
        chk(sreq, {31'd0, dmem_we}, 32'd0);
      end
      default: begin
        chk(sreq, {31'd0, dmem_we}, 32'd0);
        chk(sreq, {31'd0, dmem_re}, 32'd0);
      end
    endcase
    if (xchk) chk(xreq, dmem_wdata, xexp);
    mpc = npc;
    @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [5:0]  uop;
    logic [5:0]  fns [5];
    fns[0] = 6'h20; fns[1] = 6'h22; fns[2] = 6'h24; fns[3] = 6'h25; fns[4] = 6'h2A;
    void'($urandom(32'h5eed_0042));
    n_chk = 0; n_fail = 0;
    for (int i = 0; i < 64; i++) begin
      dmem[i] = $urandom;
    end
    dmem[1] = 32'hFFFF_FFF0; dmem[2] = 32'd5; dmem[3] = 32'd5;
    for (int i = 0; i < 64; i++) mdm[i] = dmem[i];
    for (int i = 0; i < 32; i++) mreg[i] = 32'd0;
    mpc = 32'd0;
    pc_tag = "R1";
    rst = 1'b1;
    imem_rdata = 32'd0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: first fetch at 0, cleared register
    step(enc_i(6'h2B, 5'd0, 5'd5, 16'd0), 1'b1, "R1", 32'd0);
    step(enc_i(6'h23, 5'd0, 5'd1, 16'd4));
    step(enc_i(6'h23, 5'd0, 5'd2, 16'd8));
    step(enc_i(6'h23, 5'd0, 5'd3, 16'd12));
    // R4: signed compare
    step(enc_r(6'h2A, 5'd4, 5'd1, 5'd2));
    step(enc_i(6'h2B, 5'd0, 5'd4, 16'd16), 1'b1, "R4", 32'd1);
    step(enc_r(6'h2A, 5'd4, 5'd2, 5'd1));
    step(enc_i(6'h2B, 5'd0, 5'd4, 16'd16), 1'b1, "R4", 32'd0);
    // R3: arithmetic and logic
    step(enc_r(6'h20, 5'd6, 5'd1, 5'd2));
    step(enc_i(6'h2B, 5'd0, 5'd6, 16'd20), 1'b1, "R3", 32'hFFFF_FFF5);
    step(enc_r(6'h22, 5'd6, 5'd2, 5'd1));
    step(enc_i(6'h2B, 5'd0, 5'd6, 16'd20), 1'b1, "R3", 32'd21);
    step(enc_r(6'h24, 5'd6, 5'd1, 5'd2));
    step(enc_i(6'h2B, 5'd0, 5'd6, 16'd20), 1'b1, "R3", 32'd0);
    step(enc_r(6'h25, 5'd6, 5'd1, 5'd2));
    step(enc_i(6'h2B, 5'd0, 5'd6, 16'd20), 1'b1, "R3", 32'hFFFF_FFF5);
    // R9: write to register 0 discarded
    step(enc_r(6'h20, 5'd0, 5'd1, 5'd2));
    step(enc_i(6'h2B, 5'd0, 5'd0, 16'd24), 1'b1, "R9", 32'd0);
    // R7: taken backward, then not taken
    step(enc_i(6'h04, 5'd2, 5'd3, 16'hFFFF));
    step(enc_i(6'h04, 5'd1, 5'd2, 16'd3));
    // R8: jump
    step({6'h02, 26'h3ABCDE});
    // R10: unknown opcode must not write rt
    step(enc_i(6'h3F, 5'd1, 5'd2, 16'd4));
    step(enc_i(6'h2B, 5'd0, 5'd2, 16'd28), 1'b1, "R10", 32'd5);

    for (int n = 0; n < 4000; n++) begin
      int k;
      logic [4:0]  rs, rt, rd;
      logic [31:0] ins;
      k  = $urandom_range(0, 11);
      rs = 5'($urandom_range(0, 7));
      rt = 5'($urandom_range(0, 7));
      rd = 5'($urandom_range(0, 7));
      case (k)
        0, 1, 2: ins = enc_r(fns[$urandom_range(0, 4)], rd, rs, rt);
        3, 4:    ins = enc_i(6'h23, rs, rt, 16'($urandom));
        5, 6, 7: ins = enc_i(6'h2B, rs, rt, 16'($urandom));
        8:       ins = enc_i(6'h04, rs, ($urandom_range(0, 1) == 0) ? rs : rt,
                             16'($signed($urandom_range(0, 16)) - 8));
        9:       ins = {6'h02, 26'($urandom)};
        default: begin
          uop = 6'($urandom);
          while (uop inside {6'h00, 6'h02, 6'h04, 6'h23, 6'h2B}) uop = 6'($urandom);
          ins = {uop, rs, rt, 16'($urandom)};
        end
      endcase
      step(ins);
    end

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule